// File: doc/BRIEF.md
# Two-Bank Edge/Level Interrupt Controller

This block gathers 64 interrupt inputs into two banks of 32 and presents them to a processor through a small word-wide register port and one request line. Each bank holds a latch of captured rising edges, an enable mask, a write-one-to-clear acknowledge port and a view of the raw input levels. Most bit positions are edge-triggered. A fixed group of positions in every bank is level-sensitive, and for those the raw input, masked by the enable bit, is the pending state.

An edge is captured only when it arrives while its enable bit is already set. Turning on the enable of an input that is already high therefore raises nothing; software must look at the level view to catch that case. A read-only vector word reports the highest-numbered pending source, so a handler can find the source to service in one read.

The register port is a plain select/write strobe with no back-pressure. Writes take effect at the clock edge that samples them. Read data is registered and is valid from the clock edge that sampled the read until the next read. Accesses whose two low address bits are not zero are ignored.

Top module: `twin_bank_intc`

## Requirements
- R1: After reset every enable bit and every latched event bit is 0, `irq_o` is low and the vector word reads 0x8000_0000.
- R2: The byte-address map is as follows. The vector word is at 0x00. Sources 32–63 use the bank at 0x10 and sources 0–31 use the bank at 0x20. Within a bank, the event word is at +0x0, the enable word at +0x4, the acknowledge word at +0x8 and the level word at +0xC. Register bit n is bus bit n, so byte 0 is in bits 7:0. Reading an enable word returns exactly the value last written to it.
- R3: A 0→1 transition of an edge-type input while its enable bit is 1 sets its event bit. A transition while the enable bit is 0 sets nothing.
- R4: Writing 1 to the enable bit of an input that is already high leaves the event bit at 0 and does not raise `irq_o`.
- R5: Writing 1 to a bit of an acknowledge word clears that event bit. Writing 0 leaves the bit unchanged. The acknowledge word reads as 0.
- R6: A level word returns the raw state of its 32 inputs, whatever the enable bits are.
- R7: Bit positions 20–28 of each bank are level-sensitive; when LEVEL_WIDE=1 the group is 20–29. For these bits the pending state is input AND enable, and the event bit stays 0.
- R8: `irq_o` is high one clock after any source is pending (pending means an enabled event bit, or an enabled level input), and low one clock after none is.
- R9: The vector word holds the index of the highest-numbered pending source in bits 5:0. Sources 32–63 outrank sources 0–31, and a higher bit outranks a lower one. Bit 31 is set, with the index bits 0, when nothing is pending.
- R10: When an acknowledge write and a new edge on the same enabled input meet in one clock, the event bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Interrupt inputs, source n on bit n |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address in the 0x40 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Request to the processor |

## Verification
Two functions can fall in the same clock. One is an acknowledge write that clears an event bit. The other is a fresh rising edge on that same input, which sets the bit. The bench brings this about by lowering an enabled, latched input and then raising it again at the same falling edge at which it drives the acknowledge write. The event word is then read back and must still show the bit. A second acknowledge, with no new edge, must clear it, which shows that the first acknowledge was not lost through a decoding fault.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_W  = 32;
  localparam int N_BANKS = 2;
  localparam int N_SRC   = BANK_W * N_BANKS;
  localparam int IDX_W   = $clog2(N_SRC);
  localparam int ADDR_W  = 6;

  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } reg_sel_e;

  localparam logic [31:0] VEC_NONE = 32'h8000_0000;

  // Address bits 5:4 that select a bank: low sources at 0x20, high at 0x10.
  function automatic logic [1:0] bank_window(int b);
    return (b == 0) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [BANK_W-1:0] level_bits(bit wide);
    return wide ? 32'h3FF0_0000 : 32'h1FF0_0000;
  endfunction
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int           W     = 32,
  parameter logic [W-1:0] LMASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         en_we,
  input  logic         ack_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] event_q,
  output logic [W-1:0] enable_q,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] clr;

  assign rise = src & ~prev_q & ~LMASK;
  assign clr  = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      event_q  <= '0;
      enable_q <= '0;
    end else begin
      prev_q  <= src;
      // a new edge wins over a clear in the same cycle
      event_q <= (event_q & ~clr) | (rise & enable_q);
      if (en_we) enable_q <= wdata;
    end
  end

  assign pend = enable_q & ((event_q & ~LMASK) | (src & LMASK));

  AST_EVENT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((event_q & ~$past(event_q)) & ~$past(enable_q)) == '0); // R3
  AST_EVENT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((event_q & ~$past(event_q)) & $past(prev_q)) == '0); // R4
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(enable_q)); // R2
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend,
  output logic [IW-1:0] idx,
  output logic          none
);
  always_comb begin
    idx  = '0;
    none = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) begin
        idx  = IW'(i);
        none = 1'b0;
      end
    end
  end

  AST_VECTOR_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !none |-> pend[idx]); // R9
endmodule

// File: rtl/twin_bank_intc.sv
module twin_bank_intc
  import intc_pkg::*;
#(
  parameter bit LEVEL_WIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam logic [BANK_W-1:0] LMASK = level_bits(LEVEL_WIDE);

  logic              word_ok;
  reg_sel_e          rsel;
  logic [N_SRC-1:0]  pend_all;
  logic [BANK_W-1:0] ev_a   [N_BANKS];
  logic [BANK_W-1:0] en_a   [N_BANKS];
  logic [BANK_W-1:0] pend_a [N_BANKS];
  logic [BANK_W-1:0] rd_bank[N_BANKS];
  logic [IDX_W-1:0]  vec_idx;
  logic              vec_none;
  logic [BANK_W-1:0] rd_next;

  assign word_ok = bus_sel && (bus_addr[1:0] == 2'b00);
  assign rsel    = reg_sel_e'(bus_addr[3:2]);

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = word_ok && (bus_addr[5:4] == bank_window(b));

    intc_bank #(.W(BANK_W), .LMASK(LMASK)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (irq_in[b*BANK_W +: BANK_W]),
      .en_we   (hit && bus_wr && (rsel == REG_ENABLE)),
      .ack_we  (hit && bus_wr && (rsel == REG_ACK)),
      .wdata   (bus_wdata),
      .event_q (ev_a[b]),
      .enable_q(en_a[b]),
      .pend    (pend_a[b])
    );

    assign pend_all[b*BANK_W +: BANK_W] = pend_a[b];

    always_comb begin
      case (rsel)
        REG_EVENT:  rd_bank[b] = ev_a[b];
        REG_ENABLE: rd_bank[b] = en_a[b];
        REG_LEVEL:  rd_bank[b] = irq_in[b*BANK_W +: BANK_W];
        default:    rd_bank[b] = '0;
      endcase
    end
  end

  intc_prio #(.N(N_SRC), .IW(IDX_W)) u_prio (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (pend_all),
    .idx  (vec_idx),
    .none (vec_none)
  );

  always_comb begin
    rd_next = '0;
    if (bus_addr[5:2] == 4'b0000)
      rd_next = vec_none ? VEC_NONE : {{(BANK_W-IDX_W){1'b0}}, vec_idx};
    for (int b = 0; b < N_BANKS; b++)
      if (bus_addr[5:4] == bank_window(b)) rd_next = rd_bank[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= |pend_all;
      if (word_ok && !bus_wr) bus_rdata <= rd_next;
    end
  end

  AST_IRQ_TRACKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !$past(vec_none)); // R8
endmodule

// File: tb/twin_bank_intc_tb.sv
`timescale 1ns/1ps
module twin_bank_intc_tb;
  localparam logic [5:0] A_VEC = 6'h00;
  localparam logic [5:0] H_EV = 6'h10, H_EN = 6'h14, H_ACK = 6'h18, H_LV = 6'h1C;
  localparam logic [5:0] L_EV = 6'h20, L_EN = 6'h24, L_ACK = 6'h28, L_LV = 6'h2C;
  localparam logic [31:0] NONE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  twin_bank_intc u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(string req, logic [5:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic cleanup();
    @(negedge clk); irq_in = '0;
    wait_cyc(2);
    wr(L_EN, '0); wr(H_EN, '0);
    wr(L_ACK, '1); wr(H_ACK, '1);
    wait_cyc(2);
  endtask

  task automatic t_reset();
    check("R1 irq_o", {31'b0, irq_o}, 32'd0);
    rd_check("R1 vector", A_VEC, NONE);
    rd_check("R1 enable low", L_EN, 32'd0);
    rd_check("R1 enable high", H_EN, 32'd0);
    rd_check("R1 event low", L_EV, 32'd0);
    rd_check("R1 event high", H_EV, 32'd0);
  endtask

  task automatic t_map();
    wr(L_EN, 32'hA5C3_0F01);
    wr(H_EN, 32'h1234_5678);
    rd_check("R2 low enable readback", L_EN, 32'hA5C3_0F01);
    rd_check("R2 high enable readback", H_EN, 32'h1234_5678);
    rd_check("R5 ack reads zero", L_ACK, 32'd0);
    cleanup();
  endtask

  task automatic t_edge();
    @(negedge clk); irq_in[3] = 1'b1;
    wait_cyc(2);
    @(negedge clk); irq_in[3] = 1'b0;
    wait_cyc(2);
    rd_check("R3 disabled edge ignored", L_EV, 32'd0);
    wr(L_EN, 32'h0000_0008);
    @(negedge clk); irq_in[3] = 1'b1;
    wait_cyc(3);
    rd_check("R3 enabled edge latched", L_EV, 32'h0000_0008);
    check("R8 irq raised", {31'b0, irq_o}, 32'd1);
    rd_check("R9 vector src 3", A_VEC, 32'd3);
    wr(L_ACK, 32'hFFFF_FFF7);
    rd_check("R5 zero ack bit keeps event", L_EV, 32'h0000_0008);
    wr(L_ACK, 32'h0000_0008);
    rd_check("R5 ack clears event", L_EV, 32'd0);
    wait_cyc(1);
    check("R8 irq dropped", {31'b0, irq_o}, 32'd0);
    cleanup();
  endtask

  task automatic t_enable_high();
    @(negedge clk); irq_in[37] = 1'b1;
    wait_cyc(2);
    wr(H_EN, 32'h0000_0020);
    wait_cyc(3);
    rd_check("R4 no event on enable of high input", H_EV, 32'd0);
    check("R4 no irq", {31'b0, irq_o}, 32'd0);
    rd_check("R6 high level view", H_LV, 32'h0000_0020);
    rd_check("R4 vector none", A_VEC, NONE);
    cleanup();
  endtask

  task automatic t_level();
    @(negedge clk); irq_in[21] = 1'b1; irq_in[29] = 1'b1;
    wait_cyc(2);
    rd_check("R6 level view while disabled", L_LV, 32'h2020_0000);
    wr(L_EN, 32'h0020_0000);
    wait_cyc(2);
    check("R7 level source raises irq", {31'b0, irq_o}, 32'd1);
    rd_check("R7 vector src 21", A_VEC, 32'd21);
    rd_check("R7 level event stays zero", L_EV, 32'd0);
    @(negedge clk); irq_in[21] = 1'b0;
    wait_cyc(2);
    check("R7 level drop clears irq", {31'b0, irq_o}, 32'd0);
    rd_check("R7 vector none after drop", A_VEC, NONE);
    wr(L_EN, 32'h2000_0000);
    wait_cyc(2);
    rd_check("R7 bit 29 is edge by default", L_EV, 32'd0);
    check("R7 bit 29 no irq while held", {31'b0, irq_o}, 32'd0);
    @(negedge clk); irq_in[29] = 1'b0;
    wait_cyc(2);
    @(negedge clk); irq_in[29] = 1'b1;
    wait_cyc(2);
    rd_check("R7 bit 29 edge latched", L_EV, 32'h2000_0000);
    cleanup();
  endtask

  task automatic t_priority();
    wr(L_EN, 32'h8000_0004);
    wr(H_EN, 32'h0000_0100);
    @(negedge clk); irq_in[2] = 1'b1; irq_in[31] = 1'b1; irq_in[40] = 1'b1;
    wait_cyc(3);
    rd_check("R9 high bank wins", A_VEC, 32'd40);
    wr(H_ACK, 32'h0000_0100);
    rd_check("R9 highest bit in low bank", A_VEC, 32'd31);
    wr(L_ACK, 32'h8000_0000);
    rd_check("R9 last source", A_VEC, 32'd2);
    wr(L_ACK, 32'h0000_0004);
    rd_check("R9 none pending", A_VEC, NONE);
    wait_cyc(1);
    check("R8 irq low when empty", {31'b0, irq_o}, 32'd0);
    cleanup();
  endtask

  task automatic t_collide();
    wr(L_EN, 32'h0000_0010);
    @(negedge clk); irq_in[4] = 1'b1;
    wait_cyc(2);
    @(negedge clk); irq_in[4] = 1'b0;
    wait_cyc(2);
    @(negedge clk);
    irq_in[4] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = L_ACK; bus_wdata = 32'h0000_0010;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd_check("R10 new edge survives ack", L_EV, 32'h0000_0010);
    wr(L_ACK, 32'h0000_0010);
    rd_check("R10 plain ack then clears", L_EV, 32'd0);
    cleanup();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_map();
    t_edge();
    t_enable_high();
    t_level();
    t_priority();
    t_collide();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule